// File: doc/BRIEF.md
# Column Drain Handshake Synchronizer

This block sits below a pixel array and drains hit packets from the double-column readout chains. A chain offers a 20-bit packet and its 5-bit double-column index on a four-phase request/acknowledge handshake. The request is asynchronous to the block's clock. The block passes the request through a flop-chain synchroniser. It samples the bundled data only once the synchronised request is high, and it answers with a registered acknowledge.

Each accepted packet becomes a 25-bit record: the column index sits above the packet. The record is zero-extended to 32 bits and sent out as four 8-bit words, most significant word first, on a valid/ready stream. A test selector can restrict acceptance to a single double-column, so that one chain can be exercised on its own.

Top module: `col_drain_sync`

## Requirements
- R1: While reset is asserted and directly after it, `col_ack_o` and `out_valid_o` are low.
- R2: A rising request is acted on only after it has passed the two-flop synchroniser. With the output side idle, `col_ack_o` rises on the third clock edge after `col_req_i` goes high, and not before.
- R3: `col_ack_o` stays high while the request is held. It falls on the third clock edge after `col_req_i` goes low.
- R4: The record is `{7'b0, column[4:0], packet[19:0]}`, 32 bits wide. It is emitted as four 8-bit words, bits 31:24 first and bits 7:0 last.
- R5: A word is consumed only on a clock edge where `out_valid_o` and `out_ready_i` are both high. While a word is stalled, `out_valid_o` stays high and `out_data_o` holds its value.
- R6: Each accepted packet yields exactly four words. `out_valid_o` drops after the fourth word is accepted if no further packet is waiting.
- R7: A new request is not acknowledged while any word of the previous packet is still unaccepted.
- R8: With `test_en_i` high, a request is acknowledged only if `col_addr_i` equals `test_col_i`. Requests from any other column get no acknowledge and produce no output.
- R9: With `test_en_i` low, requests from every column index are accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| col_req_i | input | 1 | Asynchronous four-phase request from the column chain |
| col_data_i | input | 20 | Packet, stable while the request is high |
| col_addr_i | input | 5 | Double-column index bundled with the packet |
| col_ack_o | output | 1 | Registered acknowledge to the column chain |
| test_en_i | input | 1 | Restrict acceptance to one double-column |
| test_col_i | input | 5 | Double-column accepted while test_en_i is high |
| out_valid_o | output | 1 | Output word valid |
| out_data_o | output | 8 | Output word |
| out_ready_i | input | 1 | Downstream ready |

## Verification
The hardest situation to reach is a second request that arrives while the previous packet's words are still stuck behind a low ready. The acknowledge must then stay low even though the synchronised request is high. The stimulus holds ready low and completes one full handshake. It then raises a second request and waits many cycles, checking that no acknowledge appears. Only after that does it release ready. Masked requests in test mode are also held for many cycles and then withdrawn, to show that they leave no trace on the output.

// File: rtl/cds_pkg.sv
package cds_pkg;
    typedef enum logic {
        CAP_IDLE,
        CAP_HOLD
    } cap_state_e;
endpackage

// File: rtl/cds_sync.sv
module cds_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/cds_col_gate.sv
module cds_col_gate #(
    parameter int ADDR_W = 5
) (
    input  logic              test_en_i,
    input  logic [ADDR_W-1:0] test_col_i,
    input  logic [ADDR_W-1:0] col_addr_i,
    output logic              allow_o
);
    always_comb begin
        allow_o = !test_en_i || (col_addr_i == test_col_i);
    end
endmodule

// File: rtl/cds_capture.sv
module cds_capture
    import cds_pkg::*;
#(
    parameter int DATA_W = 20,
    parameter int ADDR_W = 5,
    localparam int REC_W = DATA_W + ADDR_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_sync_i,
    input  logic              allow_i,
    input  logic              sink_idle_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              ack_o,
    output logic              load_o,
    output logic [REC_W-1:0]  rec_o
);
    typedef struct packed {
        cap_state_e state;
        logic       ack;
    } cap_t;

    cap_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        load_o = 1'b0;
        rec_o  = {addr_i, data_i};
        case (st_q.state)
            CAP_IDLE: begin
                if (req_sync_i && allow_i && sink_idle_i) begin
                    st_d.state = CAP_HOLD;
                    st_d.ack   = 1'b1;
                    load_o     = 1'b1;
                end
            end
            CAP_HOLD: begin
                if (!req_sync_i) begin
                    st_d.state = CAP_IDLE;
                    st_d.ack   = 1'b0;
                end
            end
            default: st_d = '{state: CAP_IDLE, ack: 1'b0};
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{state: CAP_IDLE, ack: 1'b0};
        else         st_q <= st_d;
    end

    assign ack_o = st_q.ack;
endmodule

// File: rtl/cds_serializer.sv
module cds_serializer #(
    parameter int REC_W = 25,
    parameter int OUT_W = 8,
    localparam int NWORDS = (REC_W + OUT_W - 1) / OUT_W,
    localparam int PAD_W  = NWORDS * OUT_W,
    localparam int CNT_W  = $clog2(NWORDS + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [REC_W-1:0] rec_i,
    output logic             idle_o,
    output logic             valid_o,
    output logic [OUT_W-1:0] data_o,
    input  logic             ready_i
);
    typedef struct packed {
        logic [PAD_W-1:0] shreg;
        logic [CNT_W-1:0] left;
    } ser_t;

    ser_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i && (st_q.left == '0)) begin
            st_d.shreg = PAD_W'(rec_i);
            st_d.left  = CNT_W'(NWORDS);
        end else if (st_q.left != '0 && ready_i) begin
            st_d.shreg = st_q.shreg << OUT_W;
            st_d.left  = st_q.left - CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign idle_o  = (st_q.left == '0);
    assign valid_o = (st_q.left != '0);
    assign data_o  = st_q.shreg[PAD_W-1 -: OUT_W];
endmodule

// File: rtl/col_drain_sync.sv
module col_drain_sync #(
    parameter int DATA_W      = 20,
    parameter int ADDR_W      = 5,
    parameter int OUT_W       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int REC_W = DATA_W + ADDR_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              col_req_i,
    input  logic [DATA_W-1:0] col_data_i,
    input  logic [ADDR_W-1:0] col_addr_i,
    output logic              col_ack_o,
    input  logic              test_en_i,
    input  logic [ADDR_W-1:0] test_col_i,
    output logic              out_valid_o,
    output logic [OUT_W-1:0]  out_data_o,
    input  logic              out_ready_i
);
    logic             req_sync;
    logic             allow;
    logic             sink_idle;
    logic             load;
    logic [REC_W-1:0] rec;

    cds_sync #(.STAGES(SYNC_STAGES)) i_req_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (col_req_i),
        .sync_o  (req_sync)
    );

    cds_col_gate #(.ADDR_W(ADDR_W)) i_gate (
        .test_en_i  (test_en_i),
        .test_col_i (test_col_i),
        .col_addr_i (col_addr_i),
        .allow_o    (allow)
    );

    cds_capture #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_capture (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .req_sync_i  (req_sync),
        .allow_i     (allow),
        .sink_idle_i (sink_idle),
        .data_i      (col_data_i),
        .addr_i      (col_addr_i),
        .ack_o       (col_ack_o),
        .load_o      (load),
        .rec_o       (rec)
    );

    cds_serializer #(.REC_W(REC_W), .OUT_W(OUT_W)) i_ser (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (load),
        .rec_i   (rec),
        .idle_o  (sink_idle),
        .valid_o (out_valid_o),
        .data_o  (out_data_o),
        .ready_i (out_ready_i)
    );
endmodule

// File: rtl/cds_checker.sv
module cds_checker #(
    parameter int ADDR_W = 5,
    parameter int OUT_W  = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              req_sync,
    input logic              ack,
    input logic              out_valid,
    input logic              out_ready,
    input logic [OUT_W-1:0]  out_data,
    input logic              test_en,
    input logic [ADDR_W-1:0] test_col,
    input logic [ADDR_W-1:0] col_addr
);
    AST_ACK_AFTER_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(ack) |-> $past(req_sync)); // R2
    AST_ACK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(ack) |-> $past(!req_sync)); // R3
    AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R5
    AST_NO_ACK_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(ack) |-> !$past(out_valid)); // R7
    AST_TEST_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(ack) |-> (!$past(test_en) || ($past(col_addr) == $past(test_col)))); // R8
endmodule

bind col_drain_sync cds_checker #(.ADDR_W(ADDR_W), .OUT_W(OUT_W)) i_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_sync  (req_sync),
    .ack       (col_ack_o),
    .out_valid (out_valid_o),
    .out_ready (out_ready_i),
    .out_data  (out_data_o),
    .test_en   (test_en_i),
    .test_col  (test_col_i),
    .col_addr  (col_addr_i)
);

// File: tb/test_col_drain_sync.sv
module test_col_drain_sync;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [19:0] data = '0;
    logic [4:0]  addr = '0;
    logic        ack;
    logic        test_en = 1'b0;
    logic [4:0]  test_col = '0;
    logic        valid;
    logic [7:0]  dout;
    logic        ready = 1'b0;
    int          ready_mode = 1;
    int          total = 0;
    int          bad = 0;
    logic [7:0]  exp_q[$];

    always #2.5 clk = ~clk;

    col_drain_sync i_col_drain_sync (
        .clk_i(clk), .rst_ni(rst_n), .col_req_i(req), .col_data_i(data),
        .col_addr_i(addr), .col_ack_o(ack), .test_en_i(test_en),
        .test_col_i(test_col), .out_valid_o(valid), .out_data_o(dout),
        .out_ready_i(ready)
    );

    always @(posedge clk) begin
        #1;
        case (ready_mode)
            0: ready = ($urandom_range(0, 2) != 0);
            1: ready = 1'b1;
            default: ready = 1'b0;
        endcase
    end

    task automatic check(input bit ok, input string req_tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
        end
    endtask

    // Monitor: R4 R5 R6 word order and content
    always @(negedge clk) begin
        if (rst_n && valid && ready) begin
            if (exp_q.size() == 0) check(1'b0, "R6 extra word", dout, 0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(dout == e, "R4 word", dout, e);
            end
        end
    end

    task automatic push_rec(input logic [19:0] d, input logic [4:0] a);
        logic [31:0] r;
        r = {7'b0, a, d};
        for (int i = 3; i >= 0; i--) exp_q.push_back(r[i*8 +: 8]);
    endtask

    task automatic send(input logic [19:0] d, input logic [4:0] a, input bit push);
        int n;
        if (push) push_rec(d, a);
        @(negedge clk);
        data = d; addr = a; req = 1'b1;
        n = 0;
        while (!ack && n < 2000) begin @(negedge clk); n++; end
        check(ack, "R9 ack timeout", ack, 1);
        req = 1'b0;
        n = 0;
        while (ack && n < 2000) begin @(negedge clk); n++; end
        check(!ack, "R3 ack release timeout", ack, 0);
    endtask

    task automatic drain();
        int n = 0;
        while ((valid || exp_q.size() != 0) && n < 5000) begin @(negedge clk); n++; end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!ack && !valid, "R1 reset", {ack, valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!ack && !valid, "R1 after reset", {ack, valid}, 0);

        // R2 R3 exact handshake timing, known record words
        exp_q.push_back(8'h01); exp_q.push_back(8'hFA);
        exp_q.push_back(8'hBC); exp_q.push_back(8'hDE);
        data = 20'hABCDE; addr = 5'h1F; req = 1'b1;
        @(negedge clk); @(negedge clk);
        check(!ack, "R2 no early ack", ack, 0);
        @(negedge clk);
        check(ack, "R2 ack on third edge", ack, 1);
        repeat (5) @(negedge clk);
        check(ack, "R3 ack held", ack, 1);
        req = 1'b0;
        @(negedge clk); @(negedge clk);
        check(ack, "R3 ack not early low", ack, 0 + 1);
        @(negedge clk);
        check(!ack, "R3 ack low third edge", ack, 0);
        drain();

        // R7 back-pressure: second request blocked while words pending
        ready_mode = 2;
        send(20'h12345, 5'h03, 1'b1);
        push_rec(20'h6789A, 5'h11);
        @(negedge clk);
        data = 20'h6789A; addr = 5'h11; req = 1'b1;
        repeat (15) @(negedge clk);
        check(!ack, "R7 no ack while busy", ack, 0);
        check(valid && dout == 8'h00, "R5 stalled word held", dout, 0);
        ready_mode = 1;
        begin
            int n = 0;
            while (!ack && n < 200) begin @(negedge clk); n++; end
        end
        check(ack, "R7 ack after drain", ack, 1);
        req = 1'b0;
        while (ack) @(negedge clk);
        drain();

        // R8 test mode masking
        test_en = 1'b1; test_col = 5'd7;
        @(negedge clk);
        data = 20'hFFFFF; addr = 5'd3; req = 1'b1;
        repeat (12) @(negedge clk);
        check(!ack && !valid, "R8 masked column ignored", {ack, valid}, 0);
        req = 1'b0;
        repeat (6) @(negedge clk);
        check(!ack && !valid, "R8 masked leaves no output", {ack, valid}, 0);
        send(20'h0F0F0, 5'd7, 1'b1);
        drain();
        test_en = 1'b0;

        // R9 random traffic with random ready
        ready_mode = 0;
        for (int k = 0; k < 40; k++) begin
            send(20'($urandom()), 5'($urandom_range(0, 31)), 1'b1);
        end
        ready_mode = 1;
        drain();
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R6 all words delivered", exp_q.size(), 0);
        check(!valid, "R6 valid drops", valid, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule